// File: doc/BRIEF.md
# SPI Master Word Transfer Engine

This block is the shifting core of a serial peripheral interface master. A single strobe starts a transfer. The engine then pulls the slave select line low and moves one word in both directions at once: the transmit word goes out on the data-out line, and the bits arriving on the data-in line are collected into a receive word. When the word is complete, the select line rises again. A one-cycle completion pulse then presents the received word to the host logic.

The serial clock rate is not set here. An external rate generator supplies a tick, and each tick that arrives during a transfer produces one serial clock edge. Four choices are sampled when a transfer starts and are held until it ends:

- the clock resting level (polarity);
- the clock phase, which decides whether data is captured on the first edge of each bit period or on the second;
- the word length, 8 or 16 bits;
- the bit order, most significant bit first or least significant bit first.

The bit length and the edge count are derived from the module parameters.

Top module: `spi_xfer_master`

## Requirements
- R1: `csN` goes low on the clock edge that accepts `startReq` while idle. It stays low without a break until the edge that raises `doneP`, where it returns high. Whenever `busy` is low, `csN` is high.
- R2: While idle, `sclkOut` rests at the level of `cpolSel`, following that input with one cycle of latency.
- R3: A transfer of N bits produces exactly 2N `sclkOut` transitions. Each transition happens on a clock edge where `edgeTick` is high. After the last transition, `sclkOut` is back at the resting level of that transfer.
- R4: With phase 0 (`cphaSel`=0), `misoIn` is captured on the first edge of each bit period, which is the edge leaving the resting level. `mosiOut` changes only on the second edge. The first bit is already on `mosiOut` in the first cycle that `csN` is low.
- R5: With phase 1 (`cphaSel`=1), `mosiOut` changes on the first edge of each bit period and `misoIn` is captured on the second edge.
- R6: `wideSel`=1 selects 16-bit words, which use all of `txWord`. `wideSel`=0 selects 8-bit words, which send only `txWord[7:0]` and return the received byte in `rxWord[7:0]` with `rxWord[15:8]` zero.
- R7: `lsbFirst`=1 sends bit 0 first and stores the first bit received in bit 0. `lsbFirst`=0 sends and stores the top bit of the word first.
- R8: Every transfer is full duplex. `rxWord` holds the N bits seen on `misoIn` at the capture edges, placed according to R7.
- R9: Polarity, phase, length, bit order and the transmit word are taken at start. Changing these inputs, or pulsing `startReq`, while `busy` is high has no effect on the running transfer and does not start another one.
- R10: `doneP` is high for exactly one cycle per transfer. In that cycle `csN` is high, `busy` is low and `rxWord` holds the new word. `rxWord` changes at no other time. Reset gives `csN`=1, `busy`=0, `doneP`=0 and `rxWord`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start strobe, accepted only while idle |
| txWord | input | 16 | Word to transmit |
| cpolSel | input | 1 | Serial clock resting level |
| cphaSel | input | 1 | 0: capture on the first edge of each bit; 1: capture on the second edge |
| wideSel | input | 1 | 1: 16-bit word; 0: 8-bit word |
| lsbFirst | input | 1 | 1: least significant bit first |
| edgeTick | input | 1 | Rate strobe; one serial clock edge per tick during a transfer |
| misoIn | input | 1 | Serial data from the slave |
| sclkOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data to the slave |
| csN | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| doneP | output | 1 | One-cycle completion pulse |
| rxWord | output | 16 | Last received word |

## Verification
The bench drives all four polarity and phase combinations, both word lengths and both bit orders. It uses asymmetric transmit and receive patterns so that a bit-order reversal, a one-bit slip or a swapped capture edge each produce a visibly different word. Words consisting of single bits at one end, and all-ones against all-zeros, separate wrong length masking from wrong edge timing. A separate 8-bit case puts a nonzero upper byte in the transmit word, so an 8-bit transfer that leaks those bits shows up. One run changes every configuration input and pulses start in the middle of a transfer, which shows whether the configuration was latched at start or followed live. A behavioural slave that follows only the pins captures what the master sends.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // Per-transfer settings captured when a request is accepted
  typedef struct packed {
    logic cpha;
    logic wide;
    logic lsb;
  } xferCfg_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic park;     // idle: clock follows the resting level input
    logic load;     // accept request: capture word and settings
    logic toggle;   // flip the serial clock
    logic sample;   // capture the data-in line
    logic advance;  // step to the next bit
    logic finish;   // release select, publish the received word
  } xferStb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } xferState_t;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int WIDE_BITS   = 16,
  parameter int NARROW_BITS = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     edgeTick,
  input  logic     cfgCpha,
  input  logic     cfgWide,
  output xferStb_t stb,
  output logic     busy
);

  localparam int EDGE_W = $clog2(2 * WIDE_BITS);
  localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * WIDE_BITS - 1);
  localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * NARROW_BITS - 1);

  xferState_t        state, stateNext;
  logic [EDGE_W-1:0] edgeCnt;
  logic              leading;
  logic              lastEdge;

  // Even edge numbers leave the resting level: the first edge of each bit period
  assign leading  = ~edgeCnt[0];
  assign lastEdge = (edgeCnt == (cfgWide ? LAST_WIDE : LAST_NARROW));

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        stb.park = 1'b1;
        if (startReq) begin
          stb.load  = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        if (edgeTick) begin
          stb.toggle  = 1'b1;
          stb.sample  = cfgCpha ? ~leading : leading;
          stb.advance = cfgCpha ? (leading && (edgeCnt != '0)) : ~leading;
          if (lastEdge) stateNext = ST_FIN;
        end
      end
      ST_FIN: begin
        stb.finish = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
    end else begin
      state <= stateNext;
      if (stb.load)        edgeCnt <= '0;
      else if (stb.toggle) edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spi_xfer_datapath.sv
module spi_xfer_datapath
  import spi_xfer_pkg::*;
#(
  parameter int WIDE_BITS   = 16,
  parameter int NARROW_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xferStb_t             stb,
  input  logic                 cpolSel,
  input  xferCfg_t             cfgIn,
  input  logic [WIDE_BITS-1:0] txWord,
  input  logic                 misoIn,
  output logic                 cfgCpha,
  output logic                 cfgWide,
  output logic                 sclkOut,
  output logic                 mosiOut,
  output logic                 csN,
  output logic                 doneP,
  output logic [WIDE_BITS-1:0] rxWord
);

  localparam int CNT_W = $clog2(WIDE_BITS + 1);
  localparam int IDX_W = $clog2(WIDE_BITS);
  localparam logic [CNT_W-1:0] WIDE_LEN    = CNT_W'(WIDE_BITS);
  localparam logic [CNT_W-1:0] NARROW_LEN  = CNT_W'(NARROW_BITS);
  localparam logic [IDX_W-1:0] WIDE_TOP    = IDX_W'(WIDE_BITS - 1);
  localparam logic [IDX_W-1:0] NARROW_TOP  = IDX_W'(NARROW_BITS - 1);
  localparam logic [WIDE_BITS-1:0] NARROW_MASK =
    (WIDE_BITS'(1) << NARROW_BITS) - WIDE_BITS'(1);

  xferCfg_t             cfgQ;
  logic [WIDE_BITS-1:0] txReg;
  logic [WIDE_BITS-1:0] rxAcc;
  logic [CNT_W-1:0]     bitCnt;
  logic                 sclkQ;
  logic                 csQ;
  logic                 doneQ;
  logic [WIDE_BITS-1:0] rxQ;

  logic [CNT_W-1:0]     activeLen;
  logic [IDX_W-1:0]     topIdx;
  logic                 bitValid;
  logic [IDX_W-1:0]     pos;

  // Bit position addressed by the running bit count, per length and order
  assign activeLen = cfgQ.wide ? WIDE_LEN : NARROW_LEN;
  assign topIdx    = cfgQ.wide ? WIDE_TOP : NARROW_TOP;
  assign bitValid  = (bitCnt < activeLen);
  assign pos       = cfgQ.lsb ? bitCnt[IDX_W-1:0] : (topIdx - bitCnt[IDX_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      txReg  <= '0;
      rxAcc  <= '0;
      bitCnt <= '0;
      sclkQ  <= 1'b0;
      csQ    <= 1'b1;
      doneQ  <= 1'b0;
      rxQ    <= '0;
    end else begin
      doneQ <= 1'b0;
      if (stb.park) sclkQ <= cpolSel;
      if (stb.load) begin
        cfgQ   <= cfgIn;
        txReg  <= txWord;
        rxAcc  <= '0;
        bitCnt <= '0;
        csQ    <= 1'b0;
      end
      if (stb.toggle) sclkQ <= ~sclkQ;
      if (stb.sample && bitValid) rxAcc[pos] <= misoIn;
      if (stb.advance) bitCnt <= bitCnt + 1'b1;
      if (stb.finish) begin
        csQ   <= 1'b1;
        doneQ <= 1'b1;
        rxQ   <= cfgQ.wide ? rxAcc : (rxAcc & NARROW_MASK);
      end
    end
  end

  assign mosiOut = bitValid ? txReg[pos] : 1'b0;
  assign cfgCpha = cfgQ.cpha;
  assign cfgWide = cfgQ.wide;
  assign sclkOut = sclkQ;
  assign csN     = csQ;
  assign doneP   = doneQ;
  assign rxWord  = rxQ;

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int WIDE_BITS   = 16,
  parameter int NARROW_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [WIDE_BITS-1:0] txWord,
  input  logic                 cpolSel,
  input  logic                 cphaSel,
  input  logic                 wideSel,
  input  logic                 lsbFirst,
  input  logic                 edgeTick,
  input  logic                 misoIn,
  output logic                 sclkOut,
  output logic                 mosiOut,
  output logic                 csN,
  output logic                 busy,
  output logic                 doneP,
  output logic [WIDE_BITS-1:0] rxWord
);

  xferStb_t stb;
  xferCfg_t cfgIn;
  logic     cfgCpha;
  logic     cfgWide;

  assign cfgIn = '{cpha: cphaSel, wide: wideSel, lsb: lsbFirst};

  spi_xfer_ctrl #(
    .WIDE_BITS  (WIDE_BITS),
    .NARROW_BITS(NARROW_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .edgeTick(edgeTick),
    .cfgCpha (cfgCpha),
    .cfgWide (cfgWide),
    .stb     (stb),
    .busy    (busy)
  );

  spi_xfer_datapath #(
    .WIDE_BITS  (WIDE_BITS),
    .NARROW_BITS(NARROW_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cpolSel(cpolSel),
    .cfgIn  (cfgIn),
    .txWord (txWord),
    .misoIn (misoIn),
    .cfgCpha(cfgCpha),
    .cfgWide(cfgWide),
    .sclkOut(sclkOut),
    .mosiOut(mosiOut),
    .csN    (csN),
    .doneP  (doneP),
    .rxWord (rxWord)
  );

endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int WIDE_BITS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpolSel,
  input logic                 edgeTick,
  input logic                 sclkOut,
  input logic                 mosiOut,
  input logic                 csN,
  input logic                 busy,
  input logic                 doneP,
  input logic [WIDE_BITS-1:0] rxWord
);

  // Becomes true once two edges have passed since reset, so $past is meaningful
  logic [1:0] armCnt;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             armCnt <= '0;
    else if (armCnt != 2'd2) armCnt <= armCnt + 1'b1;
  end
  assign armed = (armCnt == 2'd2);

  AST_SELECT_SPANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy != csN); // R1

  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!busy) |-> sclkOut == $past(cpolSel)); // R2

  AST_CLOCK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    armed && busy && $past(busy) && !$past(edgeTick) |-> $stable(sclkOut)); // R3

  AST_DATA_MOVES_WITH_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    armed && !csN && $past(!csN) && $stable(sclkOut) |-> $stable(mosiOut)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R10

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> csN && !busy); // R10

  AST_RX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    armed && busy |-> $stable(rxWord)); // R9

endmodule

bind spi_xfer_master spi_xfer_master_chk #(.WIDE_BITS(WIDE_BITS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpolSel (cpolSel),
  .edgeTick(edgeTick),
  .sclkOut (sclkOut),
  .mosiOut (mosiOut),
  .csN     (csN),
  .busy    (busy),
  .doneP   (doneP),
  .rxWord  (rxWord)
);

// File: tb/sim_spi_xfer_master.sv
module sim_spi_xfer_master;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] txWord = '0;
  logic        cpolSel = 1'b0;
  logic        cphaSel = 1'b0;
  logic        wideSel = 1'b0;
  logic        lsbFirst = 1'b0;
  logic        edgeTick = 1'b0;
  logic        misoIn = 1'b0;
  logic        sclkOut, mosiOut, csN, busy, doneP;
  logic [15:0] rxWord;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int tickCnt = 0;

  // Behavioural slave state
  int          slvEdge = 0;
  int          slvBit = 0;
  int          slvLen = 8;
  bit          slvCpha = 0;
  bit          slvLsb = 0;
  logic [15:0] slvTx = '0;
  logic [15:0] slvRx = '0;
  logic        slvPrevCs = 1'b1;
  logic        slvPrevSclk = 1'b0;

  spi_xfer_master u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txWord(txWord),
    .cpolSel(cpolSel), .cphaSel(cphaSel), .wideSel(wideSel), .lsbFirst(lsbFirst),
    .edgeTick(edgeTick), .misoIn(misoIn), .sclkOut(sclkOut), .mosiOut(mosiOut),
    .csN(csN), .busy(busy), .doneP(doneP), .rxWord(rxWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tickCnt  = (tickCnt + 1) % TICK_DIV;
    edgeTick = (tickCnt == 0);
  end

  function automatic int slvIdx(int b);
    return slvLsb ? b : (slvLen - 1 - b);
  endfunction

  // Slave reacting to pin changes only, evaluated between clock edges
  always @(negedge clk) begin
    if (!csN && slvPrevCs) begin
      slvEdge = 0;
      slvBit  = 0;
      slvRx   = '0;
      misoIn  = slvTx[slvIdx(0)];
    end else if (!csN && (sclkOut != slvPrevSclk)) begin
      if (!slvCpha) begin
        if ((slvEdge % 2) == 0) begin
          if (slvBit < slvLen) slvRx[slvIdx(slvBit)] = mosiOut;
        end else begin
          slvBit = slvBit + 1;
          if (slvBit < slvLen) misoIn = slvTx[slvIdx(slvBit)];
        end
      end else begin
        if ((slvEdge % 2) == 0) begin
          if (slvEdge != 0) begin
            slvBit = slvBit + 1;
            if (slvBit < slvLen) misoIn = slvTx[slvIdx(slvBit)];
          end
        end else begin
          if (slvBit < slvLen) slvRx[slvIdx(slvBit)] = mosiOut;
        end
      end
      slvEdge = slvEdge + 1;
    end
    slvPrevCs   = csN;
    slvPrevSclk = sclkOut;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic testReset();
    check(csN == 1'b1, "R1 reset csN", csN, 1);
    check(busy == 1'b0 && doneP == 1'b0, "R10 reset busy/done", {busy, doneP}, 0);
    check(rxWord == 16'h0, "R10 reset rxWord", rxWord, 0);
  endtask

  task automatic testIdleClock();
    @(negedge clk); cpolSel = 1'b1;
    repeat (2) @(negedge clk);
    check(sclkOut == 1'b1 && csN, "R2 idle high", sclkOut, 1);
    cpolSel = 1'b0;
    repeat (2) @(negedge clk);
    check(sclkOut == 1'b0 && csN, "R2 idle low", sclkOut, 0);
  endtask

  task automatic runXfer(input bit pol, input bit ph, input bit wd, input bit lsb,
                         input logic [15:0] mtx, input logic [15:0] stx,
                         input bit disturb, input string tag);
    int          n    = wd ? 16 : 8;
    logic [15:0] mask = wd ? 16'hFFFF : 16'h00FF;
    logic        first;
    int          csHigh = 0;
    int          extra = 0;
    bit          seen = 0;
    @(negedge clk);
    cpolSel = pol; cphaSel = ph; wideSel = wd; lsbFirst = lsb; txWord = mtx;
    slvCpha = ph; slvLsb = lsb; slvLen = n; slvTx = stx & mask;
    repeat (3) @(negedge clk);
    check(sclkOut == pol, "R2 resting level before start", sclkOut, pol);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(!csN && busy, "R1 select low on start", {csN, busy}, 1);
    first = lsb ? mtx[0] : mtx[n-1];
    if (!ph) check(mosiOut == first && sclkOut == pol, "R4 first bit before first edge",
                   {sclkOut, mosiOut}, {pol, first});
    for (int c = 0; c < 4000 && !seen; c++) begin
      @(negedge clk);
      if (disturb && c == 10) begin
        txWord = ~mtx; cpolSel = ~pol; cphaSel = ~ph; wideSel = ~wd; lsbFirst = ~lsb;
        startReq = 1'b1;
      end else begin
        startReq = 1'b0;
      end
      if (doneP) seen = 1;
      else if (csN) csHigh++;
    end
    check(seen, {tag, " R10 done seen"}, seen, 1);
    check(csHigh == 0, "R1 select held low", csHigh, 0);
    check(csN && !busy, "R10 released at done", {csN, busy}, 2'b10);
    check(rxWord == (stx & mask), {tag, " R8 received word"}, rxWord, stx & mask);
    check(slvRx == (mtx & mask), {tag, " transmitted word"}, slvRx, mtx & mask);
    check(slvEdge == 2 * n, "R3 edge count", slvEdge, 2 * n);
    check(sclkOut == pol, "R3 clock back at rest", sclkOut, pol);
    @(negedge clk);
    check(!doneP, "R10 single-cycle done", doneP, 0);
    if (disturb) begin
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (!csN || doneP) extra++;
      end
      check(extra == 0, "R9 no second transfer", extra, 0);
      check(rxWord == (stx & mask), "R9 result unchanged", rxWord, stx & mask);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testIdleClock();
    runXfer(0, 0, 0, 0, 16'h00A5, 16'h003C, 0, "R4");
    runXfer(0, 1, 0, 0, 16'h0096, 16'h005A, 0, "R5");
    runXfer(1, 0, 0, 1, 16'h0001, 16'h0080, 0, "R7");
    runXfer(1, 1, 1, 0, 16'hC3A5, 16'h1E2D, 0, "R6");
    runXfer(0, 0, 1, 1, 16'h8001, 16'h7FFE, 0, "R7");
    runXfer(1, 1, 0, 1, 16'hAB5C, 16'hCD39, 0, "R6");
    runXfer(0, 1, 1, 0, 16'h1234, 16'hFEDC, 1, "R9");
    runXfer(1, 0, 1, 0, 16'hFFFF, 16'h0000, 0, "R8");
    runXfer(1, 1, 1, 1, 16'h0000, 16'hFFFF, 0, "R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule